// File: doc/BRIEF.md
# Bridge Control Register File

This block holds the configuration and interrupt-control words of a host bridge as a bank of 28 registers, each 32 bits wide. A processor-side master reaches it through a plain word bus: a byte address, a write enable, write data, and read data that follows the presented address in the same cycle. Every access moves a whole word, and the register index is the byte address with its two low bits dropped.

Most words are plain storage that hold whatever was last written. Two behaviours are special. The interrupt enable word cannot be written directly: a write to a set alias ORs its ones into it, and a write to a clear alias removes its ones from it. Both aliases also keep the last value written to them. A write that takes bit 2 of the general configuration word from 0 to 1 raises a one-cycle system reset request, and the new word is still stored.

Top module: `ctrlRegFile`

## Requirements
- R1: After reset, offset 0x00 reads 0xC40, 0x04 reads 0x1384, 0x08 reads 0x2BFF8010, 0x0C reads 0x255E0091, 0x10 reads 0x6140, 0x1C and 0x20 read 0x1FF, 0x68 reads 0x8, 0x6C reads 0x10000000, every other offset from 0x00 to 0x6C reads 0, and the reset request is low.
- R2: A write to any plain storage offset (all of 0x00 to 0x6C except 0x38 and 0x3C) stores all 32 bits, and a later read at that offset returns them in the same cycle the address is presented.
- R3: A write to offset 0x30 stores the value at 0x30 and ORs it into the enable word at 0x38.
- R4: A write to offset 0x34 stores the value at 0x34 and clears in the enable word at 0x38 every bit that is one in the written value.
- R5: Writes to 0x38 and 0x3C change nothing; 0x3C always reads 0, and 0x38 changes only through the two aliases.
- R6: A write to 0x04 whose bit 2 is 1 while the stored bit 2 is 0 raises the reset request for exactly the one cycle after that write edge, and the written value is stored.
- R7: A write to 0x04 that leaves bit 2 at 1, keeps it at 0, or clears it raises no reset request.
- R8: Writes to offsets 0x70 to 0x7C change no register, and reads there return 0.
- R9: Address bits 1:0 are ignored; the index is the byte address shifted right by two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 7 | Byte address of the access |
| busWe | input | 1 | Write strobe for the current cycle |
| busWdata | input | 32 | Data to write |
| busRdata | output | 32 | Word at busAddr, zero when unmapped |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The bench goes after the enable word: it stacks several set writes, then a partial clear, then direct writes to the read-only offsets; a design that decoded 0x38 as plain storage, or let the set alias overwrite rather than OR, would read back a wrong enable value. The reset request is tested with bit 2 already set, with it kept clear, and with a true 0-to-1 edge, so a level-sensitive detector pulses on the repeat write and a stretched pulse shows up in the pulse count. Writes to the unmapped top of the window are followed by a full reread of all 28 words, which catches an index that wraps into low registers, and a write with nonzero low address bits checks that those bits are dropped.

// File: rtl/ctrlRegFile_pkg.sv
package ctrlRegFile_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 7;
  localparam int NUM_REGS = 28;
  localparam int IDX_W    = ADDR_W - 2;

  // index positions the behaviour depends on
  localparam int IDX_GEN   = 1;
  localparam int IDX_ENSET = 12;
  localparam int IDX_ENCLR = 13;
  localparam int IDX_EN    = 14;
  localparam int IDX_ISR   = 15;
  localparam int RST_BIT   = 2;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrPlain;  // one-hot store strobe
    logic                setEn;    // OR write data into enable word
    logic                clrEn;    // clear write-data ones in enable word
    logic [IDX_W-1:0]    rdIdx;    // read selector
    logic                rdHit;    // read selector in range
  } regStrobes_t;

  function automatic logic [DATA_W-1:0] rstVal(int idx);
    case (idx)
      0:       rstVal = 32'h0000_0C40;
      1:       rstVal = 32'h0000_1384;
      2:       rstVal = 32'h2BFF_8010;
      3:       rstVal = 32'h255E_0091;
      4:       rstVal = 32'h0000_6140;
      7:       rstVal = 32'h0000_01FF;
      8:       rstVal = 32'h0000_01FF;
      26:      rstVal = 32'h0000_0008;
      27:      rstVal = 32'h1000_0000;
      default: rstVal = '0;
    endcase
  endfunction

endpackage

// File: rtl/regCtrl.sv
module regCtrl
  import ctrlRegFile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              genBitNow,
  output regStrobes_t       strb,
  output logic              resetReq
);

  logic [IDX_W-1:0] idx;
  logic             inRange;
  logic             genRise;

  assign idx     = busAddr[ADDR_W-1:2];
  assign inRange = idx < IDX_W'(NUM_REGS);

  always_comb begin
    strb         = '0;
    strb.rdIdx   = idx;
    strb.rdHit   = inRange;
    if (busWe && inRange) begin
      if (idx != IDX_W'(IDX_EN) && idx != IDX_W'(IDX_ISR))
        strb.wrPlain[idx] = 1'b1;
      strb.setEn = (idx == IDX_W'(IDX_ENSET));
      strb.clrEn = (idx == IDX_W'(IDX_ENCLR));
    end
  end

  assign genRise = busWe && (idx == IDX_W'(IDX_GEN)) &&
                   busWdata[RST_BIT] && !genBitNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resetReq <= 1'b0;
    else       resetReq <= genRise;
  end

endmodule

// File: rtl/regDatapath.sv
module regDatapath
  import ctrlRegFile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              genBitNow,
  output logic [DATA_W-1:0] enVal
);

  logic [DATA_W-1:0] regQ [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == IDX_EN) begin : g_en
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           regQ[i] <= rstVal(i);
        else if (strb.setEn) regQ[i] <= regQ[i] | busWdata;
        else if (strb.clrEn) regQ[i] <= regQ[i] & ~busWdata;
      end
    end else if (i == IDX_ISR) begin : g_isr
      // status word has no source inside this block
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regQ[i] <= rstVal(i);
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                regQ[i] <= rstVal(i);
        else if (strb.wrPlain[i]) regQ[i] <= busWdata;
      end
    end
  end

  assign busRdata  = strb.rdHit ? regQ[strb.rdIdx] : '0;
  assign genBitNow = regQ[IDX_GEN][RST_BIT];
  assign enVal     = regQ[IDX_EN];

endmodule

// File: rtl/ctrlRegFile.sv
module ctrlRegFile
  import ctrlRegFile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              resetReq
);

  regStrobes_t       strb;
  logic              genBitNow;
  logic [DATA_W-1:0] enValue;

  regCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busWdata  (busWdata),
    .genBitNow (genBitNow),
    .strb      (strb),
    .resetReq  (resetReq)
  );

  regDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .genBitNow (genBitNow),
    .enVal     (enValue)
  );

endmodule

// File: rtl/ctrlRegFile_chk.sv
module ctrlRegFile_chk
  import ctrlRegFile_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              resetReq,
  input logic [DATA_W-1:0] enValue
);

  logic [IDX_W-1:0] cIdx;
  assign cIdx = busAddr[ADDR_W-1:2];

  a_r3_set_or_in: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && cIdx == IDX_W'(IDX_ENSET)) |=>
      ((enValue & $past(busWdata)) == $past(busWdata)));

  a_r4_clr_removes: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && cIdx == IDX_W'(IDX_ENCLR)) |=>
      ((enValue & $past(busWdata)) == '0));

  a_r5_en_only_alias: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && (cIdx == IDX_W'(IDX_ENSET) || cIdx == IDX_W'(IDX_ENCLR))) |=>
      $stable(enValue));

  a_r5_isr_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cIdx == IDX_W'(IDX_ISR)) |-> (busRdata == '0));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> $past(busWe && cIdx == IDX_W'(IDX_GEN) && busWdata[RST_BIT]));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cIdx >= IDX_W'(NUM_REGS)) |-> (busRdata == '0));

endmodule

bind ctrlRegFile ctrlRegFile_chk u_chk (.*);

// File: tb/ctrlRegFile_tb.sv
module ctrlRegFile_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        resetReq;

  int nChecks = 0;
  int nFails  = 0;
  int pulseCnt = 0;
  bit done = 0;

  logic [31:0] model [28];
  logic [31:0] expQ [$];
  string       tagQ [$];
  event        readEv;

  always #2.5 clk = ~clk;

  ctrlRegFile u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .resetReq (resetReq)
  );

  always @(posedge clk) if (resetReq) pulseCnt++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result against the queued expectation
  initial begin
    forever begin
      @(readEv);
      while (expQ.size() > 0) begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, busRdata, e);
      end
    end
  end

  task automatic doWrite(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic doRead(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busWe = 1'b0; busAddr = a;
    #1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    ->readEv;
    #0.5;
  endtask

  task automatic readAll(input string tag);
    for (int i = 0; i < 28; i++) doRead(7'(i*4), model[i], tag);
  endtask

  initial begin
    for (int i = 0; i < 28; i++) model[i] = '0;
    model[0] = 32'h0000_0C40;  model[1] = 32'h0000_1384;
    model[2] = 32'h2BFF_8010;  model[3] = 32'h255E_0091;
    model[4] = 32'h0000_6140;  model[7] = 32'h0000_01FF;
    model[8] = 32'h0000_01FF;  model[26] = 32'h0000_0008;
    model[27] = 32'h1000_0000;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset request low", {31'd0, resetReq}, 32'd0);
    readAll("R1 reset value");

    // R2: plain storage with several patterns
    doWrite(7'h00, 32'hDEAD_BEEF); model[0]  = 32'hDEAD_BEEF;
    doWrite(7'h10, 32'h0000_0000); model[4]  = 32'h0000_0000;
    doWrite(7'h44, 32'hA5A5_5A5A); model[17] = 32'hA5A5_5A5A;
    doWrite(7'h6C, 32'hFFFF_FFFF); model[27] = 32'hFFFF_FFFF;
    doRead(7'h00, model[0],  "R2 plain 0x00");
    doRead(7'h10, model[4],  "R2 plain 0x10");
    doRead(7'h44, model[17], "R2 plain 0x44");
    doRead(7'h6C, model[27], "R2 plain 0x6C");

    // R9: low address bits dropped
    doWrite(7'h43, 32'h1234_5678); model[16] = 32'h1234_5678;
    doRead(7'h40, model[16], "R9 low bits ignored on write");
    doRead(7'h42, model[16], "R9 low bits ignored on read");

    // R3: set alias accumulates
    doWrite(7'h30, 32'h0000_00A5); model[12] = 32'h0000_00A5; model[14] = 32'h0000_00A5;
    doRead(7'h38, model[14], "R3 enable after first set");
    doWrite(7'h30, 32'h0000_0300); model[12] = 32'h0000_0300; model[14] = 32'h0000_03A5;
    doRead(7'h30, model[12], "R3 set alias stored");
    doRead(7'h38, model[14], "R3 enable ORed");

    // R4: clear alias
    doWrite(7'h34, 32'h0000_0021); model[13] = 32'h0000_0021; model[14] = 32'h0000_0384;
    doRead(7'h34, model[13], "R4 clear alias stored");
    doRead(7'h38, model[14], "R4 enable cleared");

    // R5: read-only words
    doWrite(7'h38, 32'hFFFF_FFFF);
    doRead(7'h38, model[14], "R5 enable write ignored");
    doWrite(7'h3C, 32'hFFFF_FFFF);
    doRead(7'h3C, 32'd0, "R5 status write ignored");

    // R7: no pulse cases (stored bit 2 is 1 after reset)
    pulseCnt = 0;
    doWrite(7'h04, 32'h0000_1384); model[1] = 32'h0000_1384;
    check("R7 no pulse when bit stays 1", 32'(pulseCnt), 32'd0);
    doWrite(7'h04, 32'h0000_1380); model[1] = 32'h0000_1380;
    check("R7 no pulse when bit cleared", 32'(pulseCnt), 32'd0);
    doWrite(7'h04, 32'h0000_0010); model[1] = 32'h0000_0010;
    check("R7 no pulse when bit stays 0", 32'(pulseCnt), 32'd0);

    // R6: rising edge, pulse in the cycle after the write edge
    doWrite(7'h04, 32'h0000_0004); model[1] = 32'h0000_0004;
    check("R6 pulse high after write", {31'd0, resetReq}, 32'd1);
    @(negedge clk);
    check("R6 pulse gone next cycle", {31'd0, resetReq}, 32'd0);
    check("R6 exactly one pulse", 32'(pulseCnt), 32'd1);
    doRead(7'h04, model[1], "R6 value stored");
    doWrite(7'h04, 32'h0000_0004);
    check("R7 no pulse on repeat", 32'(pulseCnt), 32'd1);

    // R8: unmapped top of window
    for (int a = 28; a < 32; a++) doWrite(7'(a*4), 32'hFFFF_FFFF);
    for (int a = 28; a < 32; a++) doRead(7'(a*4), 32'd0, "R8 unmapped reads zero");
    readAll("R8 no register disturbed");

    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog timeout actual=running expected=done");
      end
    join_any
    #1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule